// File: doc/BRIEF.md
# I2C Register-File Target with Auto-Incrementing Pointer

This block is a 7-bit I2C target that gives a host access to a byte-wide register file of 25 locations, numbered 00h to 18h. It samples the SCL and SDA lines with a faster system clock and detects start, stop and repeated-start conditions. It matches one of two device addresses, chosen by a strap input, and drives SDA low for acknowledge and read data. The register file itself is outside the block. The block presents one pointer as the register address and gives two strobes: a write strobe and a read-capture strobe.

A write transaction sends the device address, then a pointer byte, then any number of data bytes. Each data byte is committed at its acknowledge clock, and the pointer then advances. A read transaction starts at the pointer left by the previous access. To read from a chosen location, the host writes the pointer, issues a repeated start and then reads. The pointer wraps from 18h back to 00h. Locations 13h to 18h are read-only from the bus. A start or stop that interrupts a byte discards that byte.

Top module: `i2c_reg_target`

## Requirements
- R1: The target acknowledges, by holding SDA low during the 9th SCL clock, an address byte whose upper seven bits equal 0001010 (`addr_sel_i`=0) or 0001101 (`addr_sel_i`=1). Bit 0 of the address byte is R/W, with 1 meaning read.
- R2: For any other address the target gives no acknowledge and no strobe. It keeps SDA released until the next start condition.
- R3: In a write, the byte after the address byte loads the pointer from its bits 4:0, and bits 7:5 are ignored. Each later data byte is written to the pointer location, and the pointer then advances by one.
- R4: The pointer advances from 18h to 00h, for both reads and writes.
- R5: Data bytes aimed at locations 13h to 18h produce no write strobe. They are still acknowledged, and the pointer still advances.
- R6: `reg_we_o` is a single-cycle pulse. It occurs inside the high phase of the 9th SCL clock of each data byte, with `reg_addr_o` equal to the target location and `reg_wdata_o` equal to the received byte.
- R7: Read data goes out MSB first. The first byte comes from the current pointer, and the pointer advances after every byte. A pointer write followed by a repeated start and a read begins at the written pointer.
- R8: `reg_cap_o` pulses for one cycle in the acknowledge clock of a matching read address byte, before any data bit is driven. It does not pulse at any other time.
- R9: A stop or repeated start inside an address, pointer or data byte discards that byte: no strobe, and no pointer load. A start followed directly by a stop has no effect.
- R10: When the host does not acknowledge a read byte, the target releases SDA and drives nothing until the next start.
- R11: After reset, SDA is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 1 | Strap choosing between the two device addresses |
| reg_addr_o | output | 5 | Register pointer presented to the register file |
| reg_wdata_o | output | 8 | Write data, valid with `reg_we_o` |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data of the location at `reg_addr_o` |
| reg_cap_o | output | 1 | One-cycle strobe to snapshot input registers before a read |

## Verification
A wrong bit counter or a wrong state shows up on SDA within the same byte. The acknowledge moves to the wrong clock, or a data bit is driven while the host expects a released line. A pointer error stays hidden until the next read or write, and then appears as wrong data or as a strobe at the wrong address. For that reason every pointer-changing sequence in the bench ends with a read-back. A strobe error appears at once in the strobe counts, which are sampled across each acknowledge clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDATA,
    ST_WACK,
    ST_RLOAD,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

  localparam int unsigned PTR_W    = 5;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned DEV_W    = 7;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // index STAGES-1 is the synchronized value, index STAGES the previous one
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  logic scl_c, scl_q, sda_c, sda_q;
  assign scl_c = scl_p[STAGES-1];
  assign scl_q = scl_p[STAGES];
  assign sda_c = sda_p[STAGES-1];
  assign sda_q = sda_p[STAGES];

  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_q;
  assign scl_fall_o = ~scl_c & scl_q;
  assign start_o    = scl_c & scl_q & sda_q & ~sda_c;
  assign stop_o     = scl_c & scl_q & ~sda_q & sda_c;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int unsigned           PTR_W = 5,
  parameter logic [PTR_W-1:0]      LAST  = 5'h18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R4
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_q == LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [PTR_W-1:0] WR_LAST = 5'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              ptr_load_o,
  output logic [PTR_W-1:0]  ptr_val_o,
  output logic              ptr_inc_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              cap_o
);
  tgt_state_e        st;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic              oe, rw, nack, we_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      oe    <= 1'b0;
      rw    <= 1'b0;
      nack  <= 1'b0;
      we_q  <= 1'b0;
      cap_q <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      cap_q <= 1'b0;
      if (start_i) begin
        st  <= ST_ADDR;
        cnt <= '0;
        oe  <= 1'b0;
      end else if (stop_i) begin
        st  <= ST_IDLE;
        oe  <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise_i) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == dev_addr_i) begin
                  st <= ST_AACK;
                  oe <= 1'b1;
                  rw <= sh[0];
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st <= (st == ST_PTR) ? ST_PACK : ST_WACK;
                oe <= 1'b1;
              end
            end
          end
          ST_AACK: begin
            if (scl_rise_i && rw) cap_q <= 1'b1;
            else if (scl_fall_i) begin
              oe <= 1'b0;
              st <= rw ? ST_RLOAD : ST_PTR;
            end
          end
          ST_PACK: begin
            if (scl_fall_i) begin
              oe <= 1'b0;
              st <= ST_WDATA;
            end
          end
          ST_WACK: begin
            if (scl_rise_i) we_q <= (ptr_i <= WR_LAST);
            else if (scl_fall_i) begin
              oe <= 1'b0;
              st <= ST_WDATA;
            end
          end
          ST_RLOAD: begin
            sh  <= rdata_i;
            oe  <= ~rdata_i[BYTE_W-1];
            cnt <= '0;
            st  <= ST_RDATA;
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (cnt == 4'd7) begin
                oe <= 1'b0;
                st <= ST_RACK;
              end else begin
                sh  <= {sh[BYTE_W-2:0], 1'b0};
                oe  <= ~sh[BYTE_W-2];
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) nack <= sda_i;
            else if (scl_fall_i) st <= nack ? ST_IDLE : ST_RLOAD;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe;
  assign ptr_load_o = (st == ST_PACK) && scl_rise_i && !start_i && !stop_i;
  assign ptr_val_o  = sh[PTR_W-1:0];
  assign ptr_inc_o  = ((st == ST_WACK) || (st == ST_RACK)) && scl_fall_i;
  assign we_o       = we_q;
  assign wdata_o    = sh;
  assign cap_o      = cap_q;

  // R6
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  // R5
  we_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (ptr_i <= WR_LAST));
  // R8
  cap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);
  // R2
  addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ADDR) |-> !sda_oe_o);
  // R10
  nack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RACK && scl_fall_i && nack && !start_i && !stop_i) |=> (!sda_oe_o && st == ST_IDLE));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [DEV_W-1:0] DEV_ADDR_0  = 7'h0A,
  parameter logic [DEV_W-1:0] DEV_ADDR_1  = 7'h0D,
  parameter logic [PTR_W-1:0] REG_LAST    = 5'h18,
  parameter logic [PTR_W-1:0] WR_LAST     = 5'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_sel_i,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              reg_cap_o
);
  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic ptr_load, ptr_inc;
  logic [PTR_W-1:0] ptr_val, ptr;
  logic [DEV_W-1:0] dev_addr;

  assign dev_addr = addr_sel_i ? DEV_ADDR_1 : DEV_ADDR_0;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_tgt_ptr #(.PTR_W(PTR_W), .LAST(REG_LAST)) u_ptr (
    .clk_i, .rst_ni, .load_i(ptr_load), .load_val_i(ptr_val),
    .inc_i(ptr_inc), .ptr_o(ptr)
  );

  i2c_tgt_engine #(.WR_LAST(WR_LAST)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .dev_addr_i(dev_addr), .ptr_i(ptr),
    .rdata_i(reg_rdata_i), .sda_oe_o, .ptr_load_o(ptr_load), .ptr_val_o(ptr_val),
    .ptr_inc_o(ptr_inc), .we_o(reg_we_o), .wdata_o(reg_wdata_o), .cap_o(reg_cap_o)
  );

  assign reg_addr_o = ptr;

  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_c |=> !sda_oe_o);
endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int H = 10;
  localparam int NREG = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, we, cap;
  logic [4:0] raddr;
  logic [7:0] wdata, rdata;
  logic bus_sda;
  logic [7:0] mem [NREG];
  logic [7:0] expv [NREG];
  int we_cnt = 0, cap_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign bus_sda = sda_m & ~sda_oe;
  assign rdata = (raddr < NREG) ? mem[raddr] : 8'h00;

  i2c_reg_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(bus_sda), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_we_o(we),
    .reg_rdata_i(rdata), .reg_cap_o(cap)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (we) begin
        we_cnt <= we_cnt + 1;
        if (raddr < NREG) mem[raddr] <= wdata;
      end
      if (cap) cap_cnt <= cap_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(); repeat (H) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; hw(); scl = 1'b1; hw(); sda_m = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hw(); scl = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; hw(); scl = 1'b1; hw(); s = bus_sda; scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(!m_ack, s);
  endtask

  function automatic logic [4:0] nxt(input logic [4:0] p);
    return (p >= 5'h18) ? 5'h00 : p + 5'h01;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack, s;
    logic [7:0] d;
    logic [4:0] p;
    int n0, c0;
    for (int i = 0; i < NREG; i++) begin
      mem[i] = 8'h30 + 8'(i * 3);
      expv[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(sda_oe == 0 && we == 0 && cap == 0, "R11", {sda_oe, we, cap}, 0);
    rst_n = 1'b1;
    hw();
    chk(sda_oe == 0 && we == 0 && cap == 0, "R11", {sda_oe, we, cap}, 0);

    // R1 / R2 address sweep for both straps
    for (int sel = 0; sel < 2; sel++) begin
      addr_sel = sel[0];
      for (int a = 0; a < 128; a++) begin
        bit match;
        match = (a == (sel ? 7'h0D : 7'h0A));
        n0 = we_cnt; c0 = cap_cnt;
        i2c_start();
        wr_byte({a[6:0], 1'b0}, ack);
        chk(ack == match, match ? "R1" : "R2", ack, match);
        if (!match) begin
          wr_byte(8'h00, ack);
          chk(!ack && we_cnt == n0 && cap_cnt == c0, "R2", {ack, 8'(we_cnt - n0)}, 0);
        end
        i2c_stop();
      end
    end
    addr_sel = 1'b0;

    // R3 / R6 burst write; pointer upper bits ignored
    n0 = we_cnt;
    i2c_start();
    wr_byte(8'h14, ack);
    wr_byte(8'hE5, ack);
    chk(ack, "R3", ack, 1);
    for (int i = 7; i >= 0; i--) clk_bit(i[0] ? 1'b1 : 1'b0, s); // 0xAA
    sda_m = 1'b1; hw();
    c0 = we_cnt;
    scl = 1'b1; hw();
    chk(we_cnt == c0 + 1 && bus_sda == 1'b0, "R6", {8'(we_cnt - c0), 7'd0, bus_sda}, 16'h0100);
    scl = 1'b0;
    expv[5] = 8'hAA;
    wr_byte(8'hB2, ack); expv[6] = 8'hB2;
    wr_byte(8'hC3, ack); expv[7] = 8'hC3;
    i2c_stop();
    chk(we_cnt == n0 + 3, "R3", we_cnt - n0, 3);
    chk(mem[5] == 8'hAA && mem[6] == 8'hB2 && mem[7] == 8'hC3, "R3", mem[6], 8'hB2);

    // R5 read-only range; R4 write wrap
    n0 = we_cnt;
    i2c_start();
    wr_byte(8'h14, ack);
    wr_byte(8'h11, ack);
    p = 5'h11;
    for (int k = 0; k < 5; k++) begin
      d = 8'h60 + 8'(k);
      wr_byte(d, ack);
      chk(ack, "R5", ack, 1);
      if (p <= 5'h12) expv[p] = d;
      p = nxt(p);
    end
    i2c_stop();
    chk(we_cnt == n0 + 2, "R5", we_cnt - n0, 2);
    n0 = we_cnt;
    i2c_start();
    wr_byte(8'h14, ack);
    wr_byte(8'h18, ack);
    wr_byte(8'h9D, ack);
    wr_byte(8'h5E, ack); expv[0] = 8'h5E;
    i2c_stop();
    chk(we_cnt == n0 + 1 && mem[0] == 8'h5E && mem[24] == expv[24], "R4", mem[0], 8'h5E);

    // R7 / R8 current-address read from 01h, NACK then R10 release
    c0 = cap_cnt;
    i2c_start();
    wr_byte(8'h15, ack);
    chk(ack && cap_cnt == c0 + 1, "R8", cap_cnt - c0, 1);
    p = 5'h01;
    for (int k = 0; k < 3; k++) begin
      rd_byte(k != 2, d);
      chk(d == expv[p], "R7", d, expv[p]);
      p = nxt(p);
    end
    chk(cap_cnt == c0 + 1, "R8", cap_cnt - c0, 1);
    for (int k = 0; k < 9; k++) begin
      clk_bit(1'b1, s);
      chk(s == 1'b1, "R10", s, 1);
    end
    i2c_stop();

    // R7 / R4 combined read across wrap
    i2c_start();
    wr_byte(8'h14, ack);
    wr_byte(8'h16, ack);
    i2c_start();
    wr_byte(8'h15, ack);
    chk(ack, "R7", ack, 1);
    p = 5'h16;
    for (int k = 0; k < 4; k++) begin
      rd_byte(k != 3, d);
      chk(d == expv[p], "R4", d, expv[p]);
      p = nxt(p);
    end
    i2c_stop();
    i2c_start();
    wr_byte(8'h15, ack);
    rd_byte(1'b0, d);
    i2c_stop();
    chk(d == expv[1], "R7", d, expv[1]);

    // R9 stop inside a data byte
    n0 = we_cnt;
    i2c_start();
    wr_byte(8'h14, ack);
    wr_byte(8'h08, ack);
    for (int k = 0; k < 4; k++) clk_bit(1'b0, s);
    i2c_stop();
    chk(we_cnt == n0 && mem[8] == expv[8], "R9", we_cnt - n0, 0);
    i2c_start();
    wr_byte(8'h15, ack);
    rd_byte(1'b0, d);
    i2c_stop();
    chk(d == expv[8], "R9", d, expv[8]);

    // R9 repeated start inside pointer byte keeps old pointer (09h)
    i2c_start();
    wr_byte(8'h14, ack);
    for (int k = 0; k < 3; k++) clk_bit(1'b1, s);
    i2c_start();
    wr_byte(8'h15, ack);
    rd_byte(1'b0, d);
    i2c_stop();
    chk(d == expv[9], "R9", d, expv[9]);

    // R9 stop inside address byte, and start directly followed by stop
    n0 = we_cnt; c0 = cap_cnt;
    i2c_start();
    clk_bit(1'b0, s); clk_bit(1'b0, s); clk_bit(1'b0, s);
    i2c_stop();
    i2c_start();
    i2c_stop();
    chk(we_cnt == n0 && cap_cnt == c0 && sda_oe == 0, "R9", we_cnt - n0, 0);
    i2c_start();
    wr_byte(8'h15, ack);
    rd_byte(1'b0, d);
    i2c_stop();
    chk(d == expv[10], "R9", d, expv[10]);

    // R3 / R5 final register-file image
    for (int i = 0; i < NREG; i++)
      chk(mem[i] == expv[i], (i >= 8'h13) ? "R5" : "R3", mem[i], expv[i]);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule